// File: doc/BRIEF.md
# BCD clock calendar counter

This block keeps time of day and calendar date entirely in packed BCD. A single-cycle enable, `tick`, pulses at 100 Hz. Each accepted pulse advances a chain of counters. The chain runs from hundredths of seconds through seconds, minutes, hours, day of week, date, month and year. Hours count in either a 24-hour format or a 12-hour format with a PM flag. The date rolls over at the true end of each month, and February gains a 29th day in leap years.

The eight byte registers are loaded together, in one cycle, from a 64-bit image. They are always visible as a 64-bit snapshot. The time-format bit sits in the hours byte. The oscillator-stop bit and the reset-pin enable bit sit in the day byte. All three flags survive every rollover. The block also reports when an external active-low reset input would abort a transfer.

Top module: `bcd_rtc_core`

## Requirements
- R1: After a synchronous low on `rst_n`, the snapshot reads year 00, month 01, date 01, day 01, hours 00 in 24-hour format, minutes 00, seconds 00 and hundredths 00. The two day-register control bits are 0.
- R2: Byte layout: byte 0 holds hundredths (00-99), byte 1 seconds (00-59), byte 2 minutes (00-59), byte 3 hours, byte 4 day of week, byte 5 date, byte 6 month and byte 7 year. Byte i of `rd_data`/`load_data` is bits 8i+7..8i. Each accepted tick adds one to the hundredths. A byte that passes its maximum returns to 00 and carries into the next byte.
- R3: When hours bit 7 is 0 (24-hour format), hours bits 5:4 hold the tens digit. 23:59:59.99 rolls to 00:00:00.00 and advances the date.
- R4: When hours bit 7 is 1 (12-hour format), bit 5 is the PM flag (1 = PM) and bit 4 is the tens digit. Hour 11 at x:59:59.99 goes to 12 and toggles the flag. Hour 12 goes to 01 with the flag unchanged. The date advances only when the flag goes from PM to AM.
- R5: The date returns to 01 after day 30 in months 04, 06, 09 and 11. In February it returns after day 28, or after day 29 when the year is divisible by 4. In every other month it returns after day 31.
- R6: On a date advance, the day of week steps from 1 up to 7 and then wraps to 1. A month rollover steps the month, and month 12 wraps to 01 and increments the year. Year 99 wraps to 00.
- R7: Day byte bit 5 set to 1 stops the counter, and ticks then change nothing. When it is 0, ticks advance the counter.
- R8: When `load_en` is high, every register takes the load image in that cycle, even if `tick` is also high.
- R9: Reserved bits always read 0: seconds and minutes bit 7, hours bit 6, day bits 7, 6 and 3, date bits 7:6, month bits 7:5.
- R10: `xfer_abort` is high exactly when `ext_rst_n` is low and day bit 4 is 0. With day bit 4 at 1, `ext_rst_n` has no effect.
- R11: Counting never changes hours bit 7 or day bits 5:4. Only a load changes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle 100 Hz advance enable |
| load_en | input | 1 | Parallel load of all eight registers |
| load_data | input | 64 | Load image, byte i = register i |
| ext_rst_n | input | 1 | External active-low transfer reset request |
| rd_data | output | 64 | Snapshot of all eight registers |
| xfer_abort | output | 1 | Transfer abort request after gating by day bit 4 |

## Verification
The two functions that can fall in the same cycle are a parallel load and a tick that would otherwise advance the counter. The bench provokes this by raising `load_en` and `tick` together. It does so on values next to a rollover, so a tick that slipped through would visibly carry. The bench judges the snapshot one edge later against a behavioural model that applies only the load. A second collision, a tick while the stop bit is set, is judged the same way against an unchanged model.

// File: rtl/rtc_pkg.sv
// Package: shared widths, reserved-bit mask and BCD helper functions for the
// clock calendar. Assumes all stored digits are valid packed BCD.
package rtc_pkg;
    localparam int REG_W  = 8;
    localparam int REG_N  = 8;
    localparam int SNAP_W = REG_W * REG_N;

    // Bits that may hold a 1, byte 7 down to byte 0
    localparam logic [SNAP_W-1:0] KEEP_MASK =
        {8'hFF, 8'h1F, 8'h3F, 8'h37, 8'hBF, 8'h7F, 8'h7F, 8'hFF};

    localparam logic [SNAP_W-1:0] RESET_IMAGE =
        {8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00};

    typedef struct packed {
        logic [REG_W-1:0] val;
        logic             wrap;
    } bcd_step_t;

    // One BCD increment with wrap from last back to first
    function automatic bcd_step_t bcd_next(input logic [REG_W-1:0] v,
                                           input logic [REG_W-1:0] last,
                                           input logic [REG_W-1:0] first);
        bcd_step_t r;
        if (v >= last) begin
            r.val  = first;
            r.wrap = 1'b1;
        end else if (v[3:0] == 4'd9) begin
            r.val  = {v[7:4] + 4'd1, 4'd0};
            r.wrap = 1'b0;
        end else begin
            r.val  = {v[7:4], v[3:0] + 4'd1};
            r.wrap = 1'b0;
        end
        return r;
    endfunction

    // BCD year divisible by four
    function automatic logic leap_year(input logic [REG_W-1:0] yr);
        logic [3:0] u;
        u = yr[3:0];
        if (!yr[4]) return (u == 4'd0) || (u == 4'd4) || (u == 4'd8);
        else        return (u == 4'd2) || (u == 4'd6);
    endfunction

    // Last valid date of a BCD month
    function automatic logic [REG_W-1:0] month_last(input logic [REG_W-1:0] mon,
                                                    input logic leap);
        case (mon)
            8'h02:                      return leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction
endpackage

// File: rtl/rtc_clock_chain.sv
// Time-of-day chain: hundredths, seconds, minutes and hours.
// Purely combinational; assumes valid BCD inputs. Raises day_carry when the
// hour wraps past midnight in either hour format.
module rtc_clock_chain
    import rtc_pkg::*;
(
    input  logic             step,
    input  logic [REG_W-1:0] hund,
    input  logic [REG_W-1:0] sec,
    input  logic [REG_W-1:0] mins,
    input  logic [REG_W-1:0] hour,
    output logic [REG_W-1:0] hund_n,
    output logic [REG_W-1:0] sec_n,
    output logic [REG_W-1:0] mins_n,
    output logic [REG_W-1:0] hour_n,
    output logic             day_carry
);
    bcd_step_t h_s, s_s, m_s, hr_s;
    logic      roll_s, roll_m, roll_h;
    logic [REG_W-1:0] hv;
    logic      flag_n;

    // Sub-hour ripple from hundredths to minutes
    always_comb begin
        h_s    = bcd_next(hund, 8'h99, 8'h00);
        s_s    = bcd_next(sec,  8'h59, 8'h00);
        m_s    = bcd_next(mins, 8'h59, 8'h00);
        roll_s = step && h_s.wrap;
        roll_m = roll_s && s_s.wrap;
        roll_h = roll_m && m_s.wrap;
        hund_n = step   ? h_s.val : hund;
        sec_n  = roll_s ? s_s.val : sec;
        mins_n = roll_m ? m_s.val : mins;
    end

    // Hour step for the selected format, keeping the format bit
    always_comb begin
        hour_n    = hour;
        day_carry = 1'b0;
        hv        = '0;
        hr_s      = '0;
        flag_n    = hour[5];
        if (hour[7]) begin
            hv = {3'b000, hour[4:0]};
            if (hv >= 8'h12) begin
                hv = 8'h01;
            end else if (hv == 8'h11) begin
                hv     = 8'h12;
                flag_n = ~hour[5];
            end else begin
                hr_s = bcd_next(hv, 8'h12, 8'h01);
                hv   = hr_s.val;
            end
            if (roll_h) begin
                hour_n    = {1'b1, 1'b0, flag_n, hv[4:0]};
                day_carry = hour[5] && !flag_n;
            end
        end else begin
            hr_s = bcd_next({2'b00, hour[5:0]}, 8'h23, 8'h00);
            if (roll_h) begin
                hour_n    = {2'b00, hr_s.val[5:0]};
                day_carry = hr_s.wrap;
            end
        end
    end
endmodule

// File: rtl/rtc_calendar_chain.sv
// Calendar chain: day of week, date, month and year, stepped by the day carry.
// Purely combinational; control bits in the day byte pass through unchanged.
module rtc_calendar_chain
    import rtc_pkg::*;
(
    input  logic             step,
    input  logic [REG_W-1:0] dow,
    input  logic [REG_W-1:0] date,
    input  logic [REG_W-1:0] mon,
    input  logic [REG_W-1:0] yr,
    output logic [REG_W-1:0] dow_n,
    output logic [REG_W-1:0] date_n,
    output logic [REG_W-1:0] mon_n,
    output logic [REG_W-1:0] yr_n
);
    bcd_step_t d_s, dt_s, mo_s, y_s;
    logic [REG_W-1:0] last_day;

    // Month length, then date, month and year ripple
    always_comb begin
        last_day = month_last(mon, leap_year(yr));
        d_s      = bcd_next({5'b00000, dow[2:0]}, 8'h07, 8'h01);
        dt_s     = bcd_next(date, last_day, 8'h01);
        mo_s     = bcd_next(mon, 8'h12, 8'h01);
        y_s      = bcd_next(yr, 8'h99, 8'h00);
        dow_n    = step ? {2'b00, dow[5:4], 1'b0, d_s.val[2:0]} : dow;
        date_n   = step ? dt_s.val : date;
        mon_n    = (step && dt_s.wrap) ? mo_s.val : mon;
        yr_n     = (step && dt_s.wrap && mo_s.wrap) ? y_s.val : yr;
    end
endmodule

// File: rtl/bcd_rtc_core.sv
// Top: eight-byte BCD clock calendar with parallel load and snapshot read.
// Assumes tick is a one-cycle pulse at 100 Hz. A load wins over a tick;
// reserved bits are cleared on load and never set by counting.
module bcd_rtc_core
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              load_en,
    input  logic [SNAP_W-1:0] load_data,
    input  logic              ext_rst_n,
    output logic [SNAP_W-1:0] rd_data,
    output logic              xfer_abort
);
    logic [REG_W-1:0] regs_q [REG_N];
    logic [REG_W-1:0] regs_d [REG_N];
    logic             osc_stop, adv, day_carry;

    assign osc_stop   = regs_q[4][5];
    assign adv        = tick && !osc_stop;
    assign xfer_abort = !ext_rst_n && !regs_q[4][4];

    rtc_clock_chain u_clock (
        .step(adv), .hund(regs_q[0]), .sec(regs_q[1]), .mins(regs_q[2]),
        .hour(regs_q[3]), .hund_n(regs_d[0]), .sec_n(regs_d[1]),
        .mins_n(regs_d[2]), .hour_n(regs_d[3]), .day_carry(day_carry)
    );

    rtc_calendar_chain u_cal (
        .step(day_carry), .dow(regs_q[4]), .date(regs_q[5]), .mon(regs_q[6]),
        .yr(regs_q[7]), .dow_n(regs_d[4]), .date_n(regs_d[5]),
        .mon_n(regs_d[6]), .yr_n(regs_d[7])
    );

    // Register bank: reset, masked parallel load, or counter advance
    always_ff @(posedge clk) begin
        for (int i = 0; i < REG_N; i++) begin
            if (!rst_n)
                regs_q[i] <= RESET_IMAGE[i*REG_W +: REG_W];
            else if (load_en)
                regs_q[i] <= load_data[i*REG_W +: REG_W] & KEEP_MASK[i*REG_W +: REG_W];
            else
                regs_q[i] <= regs_d[i];
        end
    end

    // Snapshot assembly
    for (genvar g = 0; g < REG_N; g++) begin : g_snap
        assign rd_data[g*REG_W +: REG_W] = regs_q[g];
    end

    // R2
    hund_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && adv && regs_q[0] == 8'h99)
        |=> (regs_q[0] == 8'h00 && regs_q[1] != $past(regs_q[1])));

    // R3
    midnight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && adv && regs_q[3] == 8'h23 && regs_q[2] == 8'h59 &&
         regs_q[1] == 8'h59 && regs_q[0] == 8'h99)
        |=> (regs_q[3] == 8'h00 && regs_q[5] != $past(regs_q[5])));

    // R7
    osc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && osc_stop) |=> $stable(rd_data));

    // R8
    load_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && tick) |=> (rd_data == ($past(load_data) & KEEP_MASK)));

    // R9
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & ~KEEP_MASK) == '0);

    // R10
    abort_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        regs_q[4][4] |-> !xfer_abort);

    // R11
    mode_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> ($stable(regs_q[3][7]) && $stable(regs_q[4][5:4])));
endmodule

// File: tb/tb_bcd_rtc_core.sv
module tb_bcd_rtc_core;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        load_en = 1'b0;
    logic [63:0] load_data = '0;
    logic        ext_rst_n = 1'b1;
    logic [63:0] rd_data;
    logic        xfer_abort;

    int total = 0;
    int bad = 0;
    string cur_req = "R1";

    // Behavioural model state
    int m_hu, m_se, m_mi, m_hr, m_dy, m_dt, m_mo, m_yr;
    bit m_12, m_pm, m_osc, m_rsen;

    bcd_rtc_core dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .load_en(load_en),
        .load_data(load_data), .ext_rst_n(ext_rst_n),
        .rd_data(rd_data), .xfer_abort(xfer_abort)
    );

    always #(PERIOD/2) clk = ~clk;

    function automatic logic [7:0] tb(input int n);
        return 8'((n / 10) * 16 + (n % 10));
    endfunction

    function automatic int fb(input logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    // Image from bytes, year down to hundredths
    function automatic logic [63:0] img(input logic [7:0] y, mo, dt, dy, hr, mi, se, hu);
        return {y, mo, dt, dy, hr, mi, se, hu};
    endfunction

    function automatic logic [63:0] expect_image();
        logic [7:0] hb, db, t;
        t = tb(m_hr);
        if (m_12) hb = {1'b1, 1'b0, m_pm, t[4:0]};
        else      hb = {2'b00, t[5:0]};
        db = {2'b00, m_osc, m_rsen, 1'b0, 3'(m_dy)};
        return {tb(m_yr), tb(m_mo), tb(m_dt), db, hb, tb(m_mi), tb(m_se), tb(m_hu)};
    endfunction

    function automatic int mlen(input int mo, input int yr);
        if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    task automatic model_reset();
        m_hu = 0; m_se = 0; m_mi = 0; m_hr = 0; m_12 = 0; m_pm = 0;
        m_dy = 1; m_dt = 1; m_mo = 1; m_yr = 0; m_osc = 0; m_rsen = 0;
    endtask

    task automatic model_day();
        m_dy = (m_dy == 7) ? 1 : m_dy + 1;
        m_dt++;
        if (m_dt > mlen(m_mo, m_yr)) begin
            m_dt = 1;
            m_mo++;
            if (m_mo > 12) begin
                m_mo = 1;
                m_yr = (m_yr + 1) % 100;
            end
        end
    endtask

    task automatic model_step(input logic ld, input logic [63:0] d, input logic tk);
        if (ld) begin
            m_hu = fb(d[7:0]);
            m_se = fb(d[15:8] & 8'h7F);
            m_mi = fb(d[23:16] & 8'h7F);
            m_12 = d[31];
            if (m_12) begin
                m_pm = d[29];
                m_hr = int'(d[28]) * 10 + int'(d[27:24]);
            end else begin
                m_pm = 0;
                m_hr = int'(d[29:28]) * 10 + int'(d[27:24]);
            end
            m_dy = int'(d[34:32]); m_rsen = d[36]; m_osc = d[37];
            m_dt = fb(d[47:40] & 8'h3F);
            m_mo = fb(d[55:48] & 8'h1F);
            m_yr = fb(d[63:56]);
        end else if (tk && !m_osc) begin
            m_hu++;
            if (m_hu == 100) begin
                m_hu = 0; m_se++;
                if (m_se == 60) begin
                    m_se = 0; m_mi++;
                    if (m_mi == 60) begin
                        m_mi = 0;
                        if (m_12) begin
                            if (m_hr == 12) m_hr = 1;
                            else if (m_hr == 11) begin
                                m_hr = 12;
                                if (m_pm) begin m_pm = 0; model_day(); end
                                else m_pm = 1;
                            end else m_hr++;
                        end else begin
                            m_hr++;
                            if (m_hr == 24) begin m_hr = 0; model_day(); end
                        end
                    end
                end
            end
        end
    endtask

    task automatic check_all();
        logic [63:0] e;
        logic ea;
        e = expect_image();
        total++;
        if (rd_data !== e) begin
            bad++;
            $display("FAIL %s snapshot actual=%h expected=%h", cur_req, rd_data, e);
        end
        ea = !ext_rst_n && !m_rsen;
        total++;
        if (xfer_abort !== ea) begin
            bad++;
            $display("FAIL R10 xfer_abort actual=%b expected=%b", xfer_abort, ea);
        end
    endtask

    task automatic cyc(input logic ld, input logic [63:0] d, input logic tk, input logic xr);
        load_en = ld; load_data = d; tick = tk; ext_rst_n = xr;
        @(posedge clk);
        model_step(ld, d, tk);
        @(negedge clk);
        check_all();
    endtask

    task automatic run(input int n, input bit dense);
        for (int i = 0; i < n; i++)
            cyc(1'b0, '0, dense ? 1'b1 : 1'($urandom_range(0, 1)), 1'b1);
    endtask

    task automatic ld(input logic [63:0] d, input logic tk);
        cyc(1'b1, d, tk, 1'b1);
    endtask

    initial begin
        #(PERIOD * 150000);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        // R1 reset image
        cur_req = "R1";
        check_all();

        // R2 basic ripple, dense then sparse ticks
        cur_req = "R2";
        run(250, 1);
        ld(img(8'h05, 8'h03, 8'h14, 8'h02, 8'h09, 8'h58, 8'h59, 8'h90), 1'b0);
        run(30, 1);
        run(200, 0);

        // R3 24-hour midnight; R6 full calendar wrap
        cur_req = "R3";
        ld(img(8'h99, 8'h12, 8'h31, 8'h07, 8'h23, 8'h59, 8'h59, 8'h95), 1'b0);
        cur_req = "R6";
        run(10, 1);

        // R4 12-hour: AM 11 -> PM 12, PM 12 -> 01, PM 11 -> AM 12 with date step
        cur_req = "R4";
        ld(img(8'h10, 8'h06, 8'h15, 8'h03, 8'h91, 8'h59, 8'h59, 8'h97), 1'b0);
        run(6, 1);
        ld(img(8'h10, 8'h06, 8'h15, 8'h03, 8'hB2, 8'h59, 8'h59, 8'h98), 1'b0);
        run(6, 1);
        ld(img(8'h10, 8'h06, 8'h30, 8'h03, 8'hB1, 8'h59, 8'h59, 8'h98), 1'b0);
        run(6, 1);
        ld(img(8'h10, 8'h06, 8'h15, 8'h03, 8'h92, 8'h59, 8'h59, 8'h98), 1'b0);
        run(6, 1);

        // R5 month lengths and leap years
        cur_req = "R5";
        ld(img(8'h21, 8'h04, 8'h30, 8'h01, 8'h23, 8'h59, 8'h59, 8'h98), 1'b0);
        run(5, 1);
        ld(img(8'h23, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59, 8'h98), 1'b0);
        run(5, 1);
        ld(img(8'h24, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59, 8'h98), 1'b0);
        run(5, 1);
        ld(img(8'h96, 8'h02, 8'h29, 8'h01, 8'h23, 8'h59, 8'h59, 8'h98), 1'b0);
        run(5, 1);
        ld(img(8'h22, 8'h01, 8'h30, 8'h01, 8'h23, 8'h59, 8'h59, 8'h98), 1'b0);
        run(5, 1);
        ld(img(8'h22, 8'h11, 8'h30, 8'h06, 8'h23, 8'h59, 8'h59, 8'h98), 1'b0);
        run(5, 1);

        // R7 stop bit holds the count; clearing it resumes
        cur_req = "R7";
        ld(img(8'h30, 8'h08, 8'h08, 8'h24, 8'h12, 8'h59, 8'h59, 8'h99), 1'b0);
        run(40, 1);
        ld(img(8'h30, 8'h08, 8'h08, 8'h04, 8'h12, 8'h59, 8'h59, 8'h99), 1'b0);
        run(5, 1);

        // R8 load and tick in the same cycle
        cur_req = "R8";
        ld(img(8'h99, 8'h12, 8'h31, 8'h07, 8'h23, 8'h59, 8'h59, 8'h99), 1'b1);
        ld(img(8'h99, 8'h12, 8'h31, 8'h07, 8'h23, 8'h59, 8'h59, 8'h99), 1'b1);
        run(3, 1);

        // R9 reserved bits set in the image read back as zero
        cur_req = "R9";
        ld(img(8'h45, 8'hE7, 8'hD5, 8'hCA, 8'h54, 8'hB3, 8'hA2, 8'h11), 1'b0);
        run(5, 1);

        // R10 external reset gating by day bit 4
        cur_req = "R10";
        cyc(1'b0, '0, 1'b1, 1'b0);
        cyc(1'b0, '0, 1'b1, 1'b0);
        ld(img(8'h45, 8'h07, 8'h15, 8'h12, 8'h14, 8'h33, 8'h22, 8'h11), 1'b0);
        cyc(1'b0, '0, 1'b1, 1'b0);
        cyc(1'b0, '0, 1'b1, 1'b0);
        cyc(1'b0, '0, 1'b1, 1'b1);

        // R11 mode and control bits survive long 12-hour counting
        cur_req = "R11";
        ld(img(8'h99, 8'h12, 8'h31, 8'h17, 8'hB1, 8'h58, 8'h00, 8'h00), 1'b0);
        run(12500, 1);
        run(2000, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule